// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block implements a locked configuration space that a host reaches through two byte-wide I/O ports: an index port and a data port. After reset the space is locked, so traffic on the data port has no effect. A four-byte key written to the index port opens the space. Once the space is open, the host writes a register number to the index port and then reads or writes that register through the data port. The index holds between accesses, so one index write can be followed by any number of data accesses.

Registers below 0x30 are global. They hold the logical-device selector, a 16-bit chip identifier split over two registers, a revision nibble, and an exit command that locks the space again. Registers from 0x30 upward belong to the logical device the selector currently names. Only the general-purpose I/O device (number 0x07) carries real registers: an activate bit and a 16-bit runtime base address. Their values drive downstream logic directly.

Host requests use a valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A read returns exactly one response on a valid/ready response channel. Writes return no response. `req_ready` is low only while a read response is waiting with `rsp_ready` low, so a stalled response holds back new requests.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, `cfg_unlocked` is 0, `ldn_out` is 0x00, `gpio_base` is 0x0A00, `gpio_active` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x002E) sets `cfg_unlocked` in the cycle after the fourth write is accepted. After only the first three bytes, the space is still locked.
- R3: While the space is locked, an index-port byte that does not match the expected key byte returns the matcher to its first stage. If that byte is 0x87, the matcher restarts at the second stage instead, so the sequence 0x87, 0x87, 0x01, 0x55, 0x55 unlocks the space.
- R4: While the space is locked, a read of the data port (address 0x002F) returns 0xFF. A write to the data port changes no register and no output.
- R5: While the space is unlocked, the index written to the index port stays in force for every later data access until the next index write.
- R6: Global register 0x20 reads the identifier high byte (0x87 by default), 0x21 reads the low byte (0x28), and 0x22 reads the revision in bits 3:0 with bits 7:4 zero (0x03 by default). Any other global index that has no register reads 0x00.
- R7: Register 0x07 can be read and written and holds the logical device number. `ldn_out` shows its value from the cycle after the write.
- R8: With logical device 0x07 selected, register 0x62 holds the high byte and 0x63 the low byte of `gpio_base`, and bit 0 of register 0x30 drives `gpio_active`. With any other device selected, banked registers read 0x00 and writes to them are ignored.
- R9: Writing 0x02 to register 0x02 clears `cfg_unlocked`. Writing any other value to register 0x02 leaves the space unlocked. Locking the space keeps all register values.
- R10: A read accepted at a clock edge raises `rsp_valid` with its data at that same edge. While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `req_ready` stays low.
- R11: A write to any address other than the two ports is ignored, and a read of such an address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O address of the access |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host can take the response |
| rsp_data | output | 8 | Read response data |
| cfg_unlocked | output | 1 | Configuration space is open |
| ldn_out | output | 8 | Selected logical device number |
| gpio_base | output | 16 | Runtime base address of the I/O device |
| gpio_active | output | 1 | I/O device activate bit |

## Verification
A key matcher that is stuck or at the wrong stage shows up right away. `cfg_unlocked` either fails to rise one cycle after the final key byte, or rises after a broken sequence, and every later data read then returns 0xFF instead of register contents. A wrong index or bank selection shows up on the first data read after the index write, in the response one cycle after acceptance. A write that lands in the wrong place shows on `ldn_out` or `gpio_base` one cycle later. A lost lock or unlock shows as a difference between 0xFF and real data on the very next data-port read.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int KEY_LEN = 4;

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] BANK_START  = 8'h30;
  localparam logic [7:0] REG_ACT     = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h62;
  localparam logic [7:0] EXIT_CMD    = 8'h02;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;

  // Unlock key, by stage
  function automatic logic [7:0] key_byte(input int unsigned stage);
    case (stage)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       key_hit
);
  localparam int SW = $clog2(KEY_LEN);
  localparam logic [SW-1:0] LAST = SW'(KEY_LEN - 1);

  logic [SW-1:0] stage_q;
  logic [SW-1:0] stage_d;
  logic          match;

  assign match   = (byte_in == key_byte(int'(stage_q)));
  assign key_hit = byte_valid && match && (stage_q == LAST);

  always_comb begin
    if (match)
      stage_d = (stage_q == LAST) ? '0 : stage_q + 1'b1;
    else if (byte_in == key_byte(0))
      stage_d = SW'(1);
    else
      stage_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          stage_q <= '0;
    else if (byte_valid) stage_q <= stage_d;
  end
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID       = 16'h8728,
  parameter logic [3:0]  CHIP_REV      = 4'h3,
  parameter logic [7:0]  GPIO_LDN      = 8'h07,
  parameter int          BASE_W        = 16,
  parameter logic [BASE_W-1:0] GPIO_BASE_RST = 16'h0A00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  output logic              exit_hit,
  output logic [7:0]        ldn,
  output logic [BASE_W-1:0] gpio_base,
  output logic              gpio_active
);
  localparam int BASE_BYTES = BASE_W / 8;

  logic [7:0] ldn_q;
  logic       act_q;
  logic [7:0] base_q [BASE_BYTES];
  logic       in_bank;
  logic       bank_wr;

  assign in_bank  = (idx >= BANK_START);
  assign bank_wr  = wr_en && in_bank && (ldn_q == GPIO_LDN);
  assign exit_hit = wr_en && (idx == REG_EXIT) && (wdata == EXIT_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (wr_en && idx == REG_LDN) ldn_q <= wdata;
      if (bank_wr && idx == REG_ACT) act_q <= wdata[0];
    end
  end

  // byte 0 is the most significant byte, at the lowest index
  for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base
    localparam int LSB = 8 * (BASE_BYTES - 1 - b);
    always_ff @(posedge clk) begin
      if (!rst_n)
        base_q[b] <= GPIO_BASE_RST[LSB +: 8];
      else if (bank_wr && idx == REG_BASE_HI + 8'(b))
        base_q[b] <= wdata;
    end
    assign gpio_base[LSB +: 8] = base_q[b];
  end

  always_comb begin
    rd_data = '0;
    if (!in_bank) begin
      case (idx)
        REG_LDN:   rd_data = ldn_q;
        REG_ID_HI: rd_data = CHIP_ID[15:8];
        REG_ID_LO: rd_data = CHIP_ID[7:0];
        REG_REV:   rd_data = {4'h0, CHIP_REV};
        default:   rd_data = '0;
      endcase
    end else if (ldn_q == GPIO_LDN) begin
      if (idx == REG_ACT) rd_data = {7'b0, act_q};
      for (int b = 0; b < BASE_BYTES; b++)
        if (idx == REG_BASE_HI + 8'(b)) rd_data = base_q[b];
    end
  end

  assign ldn         = ldn_q;
  assign gpio_active = act_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [AW-1:0] DATA_ADDR  = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'h8728,
  parameter logic [3:0]  CHIP_REV   = 4'h3,
  parameter logic [7:0]  GPIO_LDN   = 8'h07,
  parameter logic [15:0] GPIO_BASE_RST = 16'h0A00
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_data,
  output logic          cfg_unlocked,
  output logic [7:0]    ldn_out,
  output logic [15:0]   gpio_base,
  output logic          gpio_active
);
  logic       fire;
  logic       at_index;
  logic       at_data;
  logic       unlocked_q;
  logic [7:0] index_q;
  logic       key_hit;
  logic       exit_hit;
  logic [7:0] rf_rd;
  logic       rsp_valid_q;
  logic [7:0] rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign at_index  = (req_addr == INDEX_ADDR);
  assign at_data   = (req_addr == DATA_ADDR);

  sio_key_match u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (fire && req_write && at_index && !unlocked_q),
    .byte_in    (req_wdata),
    .key_hit    (key_hit)
  );

  sio_reg_file #(
    .CHIP_ID       (CHIP_ID),
    .CHIP_REV      (CHIP_REV),
    .GPIO_LDN      (GPIO_LDN),
    .BASE_W        (16),
    .GPIO_BASE_RST (GPIO_BASE_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (fire && req_write && at_data && unlocked_q),
    .idx         (index_q),
    .wdata       (req_wdata),
    .rd_data     (rf_rd),
    .exit_hit    (exit_hit),
    .ldn         (ldn_out),
    .gpio_base   (gpio_base),
    .gpio_active (gpio_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      index_q    <= '0;
    end else begin
      if (exit_hit)     unlocked_q <= 1'b0;
      else if (key_hit) unlocked_q <= 1'b1;
      if (fire && req_write && at_index && unlocked_q) index_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= (at_data && unlocked_q) ? rf_rd : IDLE_BYTE;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign cfg_unlocked = unlocked_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int            AW         = 16,
  parameter logic [AW-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [AW-1:0] DATA_ADDR  = 16'h002F
)(
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [7:0]    req_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [7:0]    rsp_data,
  input logic          cfg_unlocked,
  input logic [7:0]    ldn_out,
  input logic [15:0]   gpio_base,
  input logic [7:0]    index_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r10_resp: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write |=> rsp_valid);

  a_r4_locked_rd: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && req_addr == DATA_ADDR && !cfg_unlocked |=> rsp_data == 8'hFF);

  a_r4_locked_wr: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr == DATA_ADDR && !cfg_unlocked
    |=> $stable(ldn_out) && $stable(gpio_base));

  a_r2_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |->
    $past(acc && req_write && req_addr == INDEX_ADDR && req_wdata == 8'h55));

  a_r9_exit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unlocked && acc && req_write && req_addr == DATA_ADDR &&
    index_q == 8'h02 && req_wdata == 8'h02 |=> !cfg_unlocked);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .AW(AW), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .cfg_unlocked(cfg_unlocked), .ldn_out(ldn_out), .gpio_base(gpio_base),
  .index_q(index_q)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, cfg_unlocked, gpio_active;
  logic [7:0]  rsp_data, ldn_out;
  logic [15:0] gpio_base;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cfg_unlocked(cfg_unlocked), .ldn_out(ldn_out), .gpio_base(gpio_base),
    .gpio_active(gpio_active)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_valid ? rsp_data : 8'hXX;
  endtask

  task automatic send_key();
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(IDX, i); wr(DAT, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(IDX, i); rd(DAT, d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 unlocked", 16'(cfg_unlocked), 16'h0);
    chk("R1 ldn", 16'(ldn_out), 16'h0);
    chk("R1 base", gpio_base, 16'h0A00);
    chk("R1 active", 16'(gpio_active), 16'h0);
    chk("R1 rsp_valid", 16'(rsp_valid), 16'h0);
    chk("R1 req_ready", 16'(req_ready), 16'h1);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    rd(DAT, d);       chk("R4 locked read", 16'(d), 16'h00FF);
    wr(DAT, 8'h07);
    @(negedge clk);   chk("R4 locked write ldn", 16'(ldn_out), 16'h0);
    chk("R4 locked write base", gpio_base, 16'h0A00);
    rd(16'h0080, d);  chk("R11 other addr read", 16'(d), 16'h00FF);
  endtask

  task automatic t_bad_key();
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h33); wr(IDX, 8'h55);
    @(negedge clk);   chk("R3 broken key stays locked", 16'(cfg_unlocked), 16'h0);
    wr(IDX, 8'h87); wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
    @(negedge clk);   chk("R3 repeated first byte unlocks", 16'(cfg_unlocked), 16'h1);
    reg_wr(8'h02, 8'h02);
    @(negedge clk);   chk("R9 exit after R3", 16'(cfg_unlocked), 16'h0);
  endtask

  task automatic t_unlock();
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55);
    @(negedge clk);   chk("R2 three bytes locked", 16'(cfg_unlocked), 16'h0);
    wr(IDX, 8'h55);
    chk("R2 unlocked after fourth", 16'(cfg_unlocked), 16'h1);
  endtask

  task automatic t_globals();
    logic [7:0] d;
    reg_rd(8'h20, d); chk("R6 id high", 16'(d), 16'h0087);
    reg_rd(8'h21, d); chk("R6 id low", 16'(d), 16'h0028);
    reg_rd(8'h22, d); chk("R6 revision", 16'(d), 16'h0003);
    reg_rd(8'h25, d); chk("R6 unused global", 16'(d), 16'h0000);
    rd(16'h0080, d);  chk("R11 other addr read unlocked", 16'(d), 16'h00FF);
    wr(16'h002D, 8'h05);
    @(negedge clk);   chk("R11 other addr write", 16'(ldn_out), 16'h0);
  endtask

  task automatic t_ldn();
    logic [7:0] d;
    reg_wr(8'h07, 8'h07);
    chk("R7 ldn out", 16'(ldn_out), 16'h0007);
    rd(DAT, d);       chk("R7 ldn readback", 16'(d), 16'h0007);
    rd(DAT, d);       chk("R5 index held", 16'(d), 16'h0007);
  endtask

  task automatic t_gpio();
    logic [7:0] d;
    reg_wr(8'h62, 8'h12);
    rd(DAT, d);       chk("R8 base high readback", 16'(d), 16'h0012);
    reg_wr(8'h63, 8'h34);
    wr(DAT, 8'h56);
    chk("R5 second write same index", gpio_base, 16'h1256);
    reg_wr(8'h63, 8'h34);
    chk("R8 base", gpio_base, 16'h1234);
    reg_wr(8'h30, 8'h01);
    chk("R8 active", 16'(gpio_active), 16'h1);
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h62, 8'h99);
    chk("R8 other ldn write ignored", gpio_base, 16'h1234);
    reg_rd(8'h62, d); chk("R8 other ldn reads zero", 16'(d), 16'h0000);
    reg_wr(8'h07, 8'h07);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    wr(IDX, 8'h20);
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = DAT;
    @(negedge clk);
    req_valid = 0;
    chk("R10 rsp_valid", 16'(rsp_valid), 16'h1);
    chk("R10 rsp_data", 16'(rsp_data), 16'h0087);
    repeat (3) @(negedge clk);
    chk("R10 held valid", 16'(rsp_valid), 16'h1);
    chk("R10 held data", 16'(rsp_data), 16'h0087);
    chk("R10 req_ready low", 16'(req_ready), 16'h0);
    rsp_ready = 1;
    @(negedge clk);
    chk("R10 drained", 16'(rsp_valid), 16'h0);
    rd(DAT, d);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    reg_wr(8'h02, 8'h01);
    @(negedge clk);   chk("R9 wrong exit value", 16'(cfg_unlocked), 16'h1);
    wr(DAT, 8'h02);
    chk("R9 exit locks", 16'(cfg_unlocked), 16'h0);
    rd(DAT, d);       chk("R9 locked read", 16'(d), 16'h00FF);
    chk("R9 base kept", gpio_base, 16'h1234);
    chk("R9 ldn kept", 16'(ldn_out), 16'h0007);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_locked();
    t_bad_key();
    t_unlock();
    t_globals();
    t_ldn();
    t_gpio();
    t_backpressure();
    t_exit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule